// File: doc/BRIEF.md
# CRC-Guarded Secure Write Gate

This block stands between a serial command decoder and the write port of a memory array during a secure write transaction. The decoder delivers the transaction one byte at a time with a valid strobe. The first two bytes carry a memory address. A fixed-length payload of data bytes follows, and the transaction closes with a 16-bit checksum. While the bytes arrive, the gate runs a CRC over the address and the payload and keeps the payload in a local staging buffer. The memory array sees nothing during this phase.

When the final checksum byte arrives, the gate compares the received value with its own result. If the two agree, it sends the whole staged payload to memory as a back-to-back burst, one byte per cycle, at consecutive addresses. If they differ, it drops the transaction and raises a write-error flag, which serves as bit 4 of the device status register. A corrupted address bit therefore prevents the write in the same way as a corrupted data bit. A frame that ends early is handled as corrupt. The flag is volatile: the next secure write clears it when it starts.

Top module: `secure_write_gate`

## Requirements
- R1: After reset, mem_we is low, wr_err is low and busy is low.
- R2: A frame begins with frame_start. It then carries the address high byte, the address low byte, PAYLOAD (32) data bytes, the checksum high byte and the checksum low byte. Only the low ADDR_W-8 (5) bits of the address high byte are used, and its upper bits are ignored.
- R3: The checksum is CRC-16 with polynomial 0x1021 and initial value 0xFFFF. It is processed MSB first with no reflection and no final XOR. It runs over the address high byte with its upper 3 bits forced to zero, then the address low byte, then the 32 data bytes in order.
- R4: If the checksum matches, mem_we is high for exactly 32 consecutive cycles, beginning in the cycle after the last checksum byte is accepted. Write i carries address (base+i) modulo 2^ADDR_W and data byte i. busy is high during the burst.
- R5: If the checksum does not match, no write takes place and wr_err is high from the cycle after the last checksum byte is accepted. This holds whether the data, the address or the checksum was corrupted.
- R6: If frame_end arrives before all 36 bytes of a started frame are in, no write takes place and wr_err goes high in the next cycle. frame_end takes priority over a byte in the same cycle.
- R7: frame_start clears wr_err in the next cycle and restarts collection, unless a commit burst is in progress.
- R8: During a commit burst, frame_start, frame_end and bytes are ignored. The burst completes unchanged, and no new frame is being collected after it.
- R9: Bytes strobed while no frame is being collected, including bytes after the 36th, cause no write and leave wr_err unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Pulse: a secure write transaction begins |
| frame_end | input | 1 | Pulse: the transaction's select was released |
| byte_valid | input | 1 | byte_data holds a new byte |
| byte_data | input | 8 | Incoming transaction byte |
| mem_we | output | 1 | Memory write strobe, one byte per cycle |
| mem_addr | output | ADDR_W (13) | Memory write address |
| mem_wdata | output | 8 | Memory write data |
| wr_err | output | 1 | Volatile write-error flag (status bit 4) |
| busy | output | 1 | Commit burst in progress |

## Verification
The assertions check three things on every cycle: a write strobe never coincides with a raised error flag, successive writes of a burst step the address by one, and every burst lasts exactly the payload length. They also check that an early frame end or an accepted frame_start sets or clears the flag in the following cycle. The bench scenarios are needed for the rest. Only they can show that the checksum itself is computed correctly, that each single-bit corruption in address, data or checksum blocks the write, and that the written bytes match the sent payload. They also show that the address wraps at the top of memory and that strobes during a burst or between frames leave no trace.

// File: rtl/sw_gate_pkg.sv
package sw_gate_pkg;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_COLLECT = 2'd1,
      ST_COMMIT  = 2'd2
   } sw_state_e;

   // One byte through a non-reflected CRC-16, MSB first.
   function automatic logic [15:0] crc16_step(input logic [15:0] crc_in,
                                              input logic [7:0]  data_in,
                                              input logic [15:0] poly);
      logic [15:0] c;
      c = crc_in;
      for (int b = 7; b >= 0; b--) begin
         if (c[15] ^ data_in[b]) c = {c[14:0], 1'b0} ^ poly;
         else                    c = {c[14:0], 1'b0};
      end
      return c;
   endfunction

endpackage

// File: rtl/sw_crc16.sv
module sw_crc16 #(
   parameter logic [15:0] POLY = 16'h1021,
   parameter logic [15:0] SEED = 16'hFFFF
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        restart,
   input  logic        feed,
   input  logic [7:0]  din,
   output logic [15:0] crc
);
   import sw_gate_pkg::*;

   generate
      if (POLY[0] != 1'b1) begin : g_bad_poly
         $error("sw_crc16: generator polynomial must have its constant term set");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       crc <= SEED;
      else if (restart) crc <= SEED;
      else if (feed)    crc <= crc16_step(crc, din, POLY);
   end

endmodule

// File: rtl/sw_stage_buf.sv
module sw_stage_buf #(
   parameter int DEPTH = 32,
   parameter int WIDTH = 8,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             we,
   input  logic [PTR_W-1:0] waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [PTR_W-1:0] raddr,
   output logic [WIDTH-1:0] rdata
);

   generate
      if (DEPTH < 2 || DEPTH > 1024) begin : g_bad_depth
         $error("sw_stage_buf: DEPTH out of supported range 2..1024");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("sw_stage_buf: WIDTH must be positive");
      end
   endgenerate

   logic [WIDTH-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];

endmodule

// File: rtl/secure_write_gate.sv
module secure_write_gate #(
   parameter int          ADDR_W   = 13,
   parameter int          PAYLOAD  = 32,
   parameter logic [15:0] CRC_POLY = 16'h1021,
   parameter logic [15:0] CRC_SEED = 16'hFFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              frame_end,
   input  logic              byte_valid,
   input  logic [7:0]        byte_data,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   output logic              wr_err,
   output logic              busy
);
   import sw_gate_pkg::*;

   localparam int HDR     = 2;
   localparam int CRC_AT  = HDR + PAYLOAD;
   localparam int LAST    = CRC_AT + 1;
   localparam int IDX_W   = $clog2(LAST + 1);
   localparam int PTR_W   = $clog2(PAYLOAD);
   localparam int HI_BITS = ADDR_W - 8;
   localparam int RUN_W   = $clog2(PAYLOAD + 1);
   localparam logic [7:0]       HI_MASK  = 8'((1 << HI_BITS) - 1);
   localparam logic [IDX_W-1:0] C_HDR    = IDX_W'(HDR);
   localparam logic [IDX_W-1:0] C_CRC_AT = IDX_W'(CRC_AT);
   localparam logic [IDX_W-1:0] C_LAST   = IDX_W'(LAST);
   localparam logic [PTR_W-1:0] P_END    = PTR_W'(PAYLOAD - 1);

   generate
      if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_addr
         $error("secure_write_gate: ADDR_W must fit two header bytes (9..16)");
      end
      if (PAYLOAD < 2 || PAYLOAD > 256) begin : g_bad_payload
         $error("secure_write_gate: PAYLOAD out of range 2..256");
      end
   endgenerate

   sw_state_e          state;
   logic [IDX_W-1:0]   cnt;
   logic [PTR_W-1:0]   wptr;
   logic [7:0]         addr_hi, addr_lo, rx_hi;
   logic [15:0]        crc_val;
   logic [ADDR_W-1:0]  base;
   logic               collecting, take, crc_feed, buf_we, crc_ok, restart;
   logic [7:0]         crc_din;

   assign collecting = (state == ST_COLLECT);
   assign busy       = (state == ST_COMMIT);
   assign restart    = frame_start && !busy;
   assign take       = collecting && byte_valid && !frame_end && !frame_start;
   assign crc_feed   = take && (cnt < C_CRC_AT);
   assign crc_din    = (cnt == '0) ? (byte_data & HI_MASK) : byte_data;
   assign buf_we     = crc_feed && (cnt >= C_HDR);
   assign crc_ok     = ({rx_hi, byte_data} == crc_val);

   sw_crc16 #(.POLY(CRC_POLY), .SEED(CRC_SEED)) i_crc (
      .clk    (clk),
      .rst_n  (rst_n),
      .restart(restart),
      .feed   (crc_feed),
      .din    (crc_din),
      .crc    (crc_val)
   );

   sw_stage_buf #(.DEPTH(PAYLOAD), .WIDTH(8)) i_buf (
      .clk  (clk),
      .we   (buf_we),
      .waddr(PTR_W'(cnt - C_HDR)),
      .wdata(byte_data),
      .raddr(wptr),
      .rdata(mem_wdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         wptr    <= '0;
         addr_hi <= '0;
         addr_lo <= '0;
         rx_hi   <= '0;
         wr_err  <= 1'b0;
      end else if (busy) begin
         wptr <= wptr + 1'b1;
         if (wptr == P_END) state <= ST_IDLE;
      end else if (restart) begin
         state  <= ST_COLLECT;
         cnt    <= '0;
         wr_err <= 1'b0;
      end else if (collecting && frame_end) begin
         state  <= ST_IDLE;
         wr_err <= 1'b1;
      end else if (take) begin
         cnt <= cnt + 1'b1;
         if (cnt == '0)          addr_hi <= byte_data & HI_MASK;
         if (cnt == IDX_W'(1))   addr_lo <= byte_data;
         if (cnt == C_CRC_AT)    rx_hi   <= byte_data;
         if (cnt == C_LAST) begin
            if (crc_ok) begin
               state <= ST_COMMIT;
               wptr  <= '0;
            end else begin
               state  <= ST_IDLE;
               wr_err <= 1'b1;
            end
         end
      end
   end

   assign base     = {addr_hi[HI_BITS-1:0], addr_lo};
   assign mem_we   = busy;
   assign mem_addr = base + ADDR_W'(wptr);

   // Checker-only run length of the write strobe.
   logic [RUN_W-1:0] we_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      we_run <= '0;
      else if (mem_we) we_run <= we_run + 1'b1;
      else             we_run <= '0;
   end

   // R5: a failed check never lets a write through
   a_r5_no_write_on_err: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> !wr_err);

   // R4: burst addresses advance by one
   a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && $past(mem_we)) |-> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

   // R4: every burst is exactly one payload long
   a_r4_burst_len: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_we) |-> (we_run == RUN_W'(PAYLOAD)));

   // R7: an accepted start clears the flag
   a_r7_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && !busy) |=> !wr_err);

   // R6: an early end sets the flag and writes nothing
   a_r6_short_frame: assert property (@(posedge clk) disable iff (!rst_n)
      (collecting && frame_end && !frame_start) |=> (wr_err && !mem_we));

endmodule

// File: tb/test_secure_write_gate.sv
module test_secure_write_gate;

   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W = 13;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              frame_start = 1'b0, frame_end = 1'b0, byte_valid = 1'b0;
   logic [7:0]        byte_data = '0;
   logic              mem_we, wr_err, busy;
   logic [ADDR_W-1:0] mem_addr;
   logic [7:0]        mem_wdata;

   int checks = 0, errors = 0, cyc = 0;
   int wr_cnt = 0, first_wr_cyc = -1, last_byte_cyc = 0;
   logic [ADDR_W-1:0] wr_addr [64];
   logic [7:0]        wr_data [64];
   logic [7:0]        pay [32];
   logic              err_after = 1'b0;

   secure_write_gate i_secure_write_gate (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_end(frame_end),
      .byte_valid(byte_valid), .byte_data(byte_data), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .wr_err(wr_err), .busy(busy)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (mem_we) begin
         if (wr_cnt == 0) first_wr_cyc = cyc;
         if (wr_cnt < 64) begin
            wr_addr[wr_cnt] = mem_addr;
            wr_data[wr_cnt] = mem_wdata;
         end
         wr_cnt = wr_cnt + 1;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b);
      logic [15:0] r;
      r = c ^ {b, 8'h00};
      for (int k = 0; k < 8; k++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
      return r;
   endfunction

   // corrupt: 0 none, 1 data bit, 2 address bit, 3 checksum bit
   task automatic run_frame(input logic [7:0] hi, input logic [7:0] lo, input int seed,
                            input int corrupt, input int nbytes, input int gap);
      logic [7:0]  fr [36];
      logic [15:0] c;
      for (int i = 0; i < 32; i++) pay[i] = 8'(seed * 31 + i * 7 + 3);
      c = 16'hFFFF;
      c = ref_crc(c, hi & 8'h1F);
      c = ref_crc(c, lo);
      for (int i = 0; i < 32; i++) c = ref_crc(c, pay[i]);
      fr[0] = hi; fr[1] = lo;
      for (int i = 0; i < 32; i++) fr[i+2] = pay[i];
      fr[34] = c[15:8]; fr[35] = c[7:0];
      if (corrupt == 1) fr[9]  = fr[9]  ^ 8'h10;
      if (corrupt == 2) fr[1]  = fr[1]  ^ 8'h04;
      if (corrupt == 3) fr[35] = fr[35] ^ 8'h01;
      wr_cnt = 0; first_wr_cyc = -1;
      @(negedge clk) frame_start = 1'b1;
      @(negedge clk) frame_start = 1'b0;
      for (int i = 0; i < nbytes; i++) begin
         byte_valid = 1'b1; byte_data = fr[i % 36];
         last_byte_cyc = cyc;
         @(negedge clk) byte_valid = 1'b0;
         for (int g = 0; g < gap; g++) @(negedge clk);
      end
      frame_end = 1'b1;
      @(negedge clk) frame_end = 1'b0;
      err_after = wr_err;
      repeat (40) @(negedge clk);
   endtask

   task automatic expect_burst(input string req, input logic [ADDR_W-1:0] base);
      int bad = 0;
      check(wr_cnt == 32, req, wr_cnt, 32);
      for (int i = 0; i < 32 && i < wr_cnt; i++)
         if (wr_addr[i] != ADDR_W'(base + i) || wr_data[i] != pay[i]) bad++;
      check(bad == 0, req, bad, 0);
      check(err_after == 1'b0, req, int'(err_after), 0);
   endtask

   task automatic expect_reject(input string req);
      check(wr_cnt == 0, req, wr_cnt, 0);
      check(err_after == 1'b1, req, int'(err_after), 1);
      check(wr_err == 1'b1, req, int'(wr_err), 1);
   endtask

   task automatic t_reset;
      @(negedge clk);
      check(!mem_we && !wr_err && !busy, "R1 reset state",
            int'({mem_we, wr_err, busy}), 0);
   endtask

   task automatic t_good;
      run_frame(8'h03, 8'h40, 1, 0, 36, 0);
      expect_burst("R2 R3 R4 good frame", 13'h0340);
      check(first_wr_cyc == last_byte_cyc + 1, "R4 burst start cycle",
            first_wr_cyc, last_byte_cyc + 1);
      run_frame(8'h1A, 8'h07, 5, 0, 36, 2);
      expect_burst("R4 frame with gaps", 13'h1A07);
   endtask

   task automatic t_masked_hi;
      run_frame(8'hE2, 8'h11, 9, 0, 36, 0);
      expect_burst("R2 R3 upper address bits ignored", 13'h0211);
   endtask

   task automatic t_wrap;
      run_frame(8'h1F, 8'hF0, 3, 0, 36, 0);
      expect_burst("R4 address wrap", 13'h1FF0);
   endtask

   task automatic t_corrupt;
      run_frame(8'h01, 8'h00, 2, 1, 36, 0);
      expect_reject("R5 corrupted data");
      run_frame(8'h01, 8'h00, 2, 2, 36, 0);
      expect_reject("R5 corrupted address");
      run_frame(8'h01, 8'h00, 2, 3, 36, 0);
      expect_reject("R5 corrupted checksum");
   endtask

   task automatic t_short;
      run_frame(8'h00, 8'h20, 4, 0, 35, 0);
      expect_reject("R6 frame missing last byte");
      run_frame(8'h00, 8'h20, 4, 0, 1, 0);
      expect_reject("R6 frame with address byte only");
   endtask

   task automatic t_clear;
      // flag is high from the previous scenario
      @(negedge clk) frame_start = 1'b1;
      @(negedge clk) frame_start = 1'b0;
      check(wr_err == 1'b0, "R7 start clears flag", int'(wr_err), 0);
      frame_end = 1'b1;
      @(negedge clk) frame_end = 1'b0;
   endtask

   task automatic t_busy_and_idle;
      logic [7:0]  fr [36];
      logic [15:0] c;
      // good frame, with a start pulse and stray bytes during the burst
      for (int i = 0; i < 32; i++) pay[i] = 8'(i * 5 + 1);
      c = 16'hFFFF; c = ref_crc(c, 8'h00); c = ref_crc(c, 8'h80);
      for (int i = 0; i < 32; i++) c = ref_crc(c, pay[i]);
      fr[0] = 8'h00; fr[1] = 8'h80;
      for (int i = 0; i < 32; i++) fr[i+2] = pay[i];
      fr[34] = c[15:8]; fr[35] = c[7:0];
      wr_cnt = 0;
      @(negedge clk) frame_start = 1'b1;
      @(negedge clk) frame_start = 1'b0;
      for (int i = 0; i < 36; i++) begin
         byte_valid = 1'b1; byte_data = fr[i];
         @(negedge clk);
      end
      byte_valid = 1'b0;
      repeat (3) @(negedge clk);
      frame_start = 1'b1; byte_valid = 1'b1; byte_data = 8'h00;
      @(negedge clk) frame_start = 1'b0;
      for (int i = 1; i < 36; i++) begin byte_data = fr[i]; @(negedge clk); end
      byte_valid = 1'b0;
      repeat (10) @(negedge clk);
      err_after = wr_err;
      expect_burst("R8 burst unchanged by start during busy", 13'h0080);
      // bytes with no frame open: a full valid frame body, no start
      wr_cnt = 0;
      for (int i = 0; i < 36; i++) begin
         byte_valid = 1'b1; byte_data = fr[i];
         @(negedge clk);
      end
      byte_valid = 1'b0;
      repeat (40) @(negedge clk);
      check(wr_cnt == 0, "R8 R9 no frame collected after busy start", wr_cnt, 0);
      check(wr_err == 1'b0, "R9 idle bytes leave flag", int'(wr_err), 0);
   endtask

   task automatic t_extra_bytes;
      run_frame(8'h05, 8'h55, 7, 0, 40, 0);
      expect_burst("R9 bytes past the 36th ignored", 13'h0555);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_good();
      t_masked_hi();
      t_wrap();
      t_corrupt();
      t_short();
      t_clear();
      t_busy_and_idle();
      t_extra_bytes();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule